// File: doc/BRIEF.md
# Command-Driven I2C Byte Master

This block is an I2C master that moves one byte at a time under host control. The host presents a byte on `cmdData` together with a command on `cmdCode` for one cycle while `pending` is high. A start command sends a start condition, or a repeated start, followed by the byte as the address and direction. A continue command sends the next data byte, or receives the next one. A stop command ends the transfer. After each bus action the engine parks with SCL held low. It reports a 3-bit state code and raises `pending` again.

SCL and SDA are driven open-drain: `sclDrive` and `sdaDrive` pull the wire low when high, and the wire levels come back on `sclIn` and `sdaIn`. The low and high phases of SCL each last a programmable number of cycles. The high phase does not start counting until SCL reads back high. A DMA request is raised only while the engine waits in a state where a byte can move.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, stateCode is 0, pending is 1, dmaReq is 0, cmdErr is 0, and sclDrive and sdaDrive are both 0 (bus released).
- R2: A start command (cmdCode 1) in state 0 sends a start condition, then cmdData as the address byte, where bit 0 set to 1 means read. If the slave ACKs an address with bit 0 cleared, the engine ends in state 2 with pending high.
- R3: If the slave ACKs an address with bit 0 set, the engine clocks in one byte, MSB first, and ends in state 1 with that byte on rxByte.
- R4: If the address is NACKed (SDA high on the ninth clock), the engine ends in state 3.
- R5: A continue command (cmdCode 2) in state 2 transmits cmdData MSB first. It ends in state 2 if the slave ACKs and in state 4 if the slave NACKs.
- R6: dmaReq is high only while pending is high and stateCode is 1 or 2. It is low in states 0, 3 and 4.
- R7: pending goes low in the cycle after an accepted command and stays low until the resulting bus action completes.
- R8: In state 1, a continue command ACKs the held byte (SDA low on its ninth clock) and then reads the next byte. A stop or start command NACKs it (SDA released) first.
- R9: Any command not legal in the current state is ignored and sets cmdErr, which stays set until reset. This covers cmdCode 0 at any time, continue in states 0, 3 and 4, stop in state 0, and any command while pending is low.
- R10: Within a byte, each SCL low phase lasts sclLowCnt+1 cycles. Each SCL high phase lasts sclHighCnt+1 cycles, counted from the first cycle SCL reads high.
- R11: A stop command (cmdCode 3) in states 1 to 4 ends with a stop condition, both lines released, and state 0. A start command in states 1 to 4 issues a repeated start and proceeds as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclLowCnt | input | DIV_W | SCL low phase length minus one |
| sclHighCnt | input | DIV_W | SCL high phase length minus one |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdCode | input | 2 | 0 none, 1 start, 2 continue, 3 stop |
| cmdData | input | 8 | Address byte for start, data byte for continue |
| stateCode | output | 3 | Current state code 0 to 4 |
| pending | output | 1 | Engine waits for a command |
| dmaReq | output | 1 | Byte movement request |
| cmdErr | output | 1 | Sticky illegal-command flag |
| rxByte | output | 8 | Last received byte |
| sclIn | input | 1 | SCL wire level |
| sdaIn | input | 1 | SDA wire level |
| sclDrive | output | 1 | Pull SCL low |
| sdaDrive | output | 1 | Pull SDA low |

## Verification
The hardest case to reach is the acknowledge decision on a received byte. That decision is deferred until the next command arrives, so the bench must hold the engine in state 1 and then choose between continue, stop and repeated start. A behavioural slave on the wired bus records the level it sees on each ninth clock. Directed sequences and seeded random transactions drive the engine through every state-to-command pairing. These include data NACKs, non-matching addresses and commands sent while a bus action is still running.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_START = 2'd1,
    CMD_CONT  = 2'd2,
    CMD_STOP  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RXRDY   = 3'd1,
    ST_TXRDY   = 3'd2,
    ST_ADDRNAK = 3'd3,
    ST_DATANAK = 3'd4
  } code_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic       doStart;
    logic       doStop;
    logic       doWrite;
    logic       doRead;
    logic       doAck;
    logic       ackVal;
    logic [7:0] wrByte;
  } dpOps_t;

endpackage

// File: rtl/i2c_cmd_dp.sv
module i2c_cmd_dp
  import i2c_cmd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpOps_t           ops,
  input  logic [DIV_W-1:0] sclLowCnt,
  input  logic [DIV_W-1:0] sclHighCnt,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclDrvLow,
  output logic             sdaDrvLow,
  output logic             opDone,
  output logic [7:0]       rxShift
);

  localparam int FRAME_BITS = 9;
  localparam int BITS_W     = $clog2(FRAME_BITS + 1);

  typedef enum logic [3:0] {
    DP_IDLE, DP_S1, DP_S2, DP_S3, DP_P1, DP_P2, DP_P3, DP_BLO, DP_BHI
  } dpState_e;

  dpState_e               dpState;
  logic [DIV_W-1:0]       cnt;
  logic [FRAME_BITS-1:0]  txShift;
  logic [BITS_W-1:0]      bitsLeft;
  logic                   cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dpState   <= DP_IDLE;
      cnt       <= '0;
      txShift   <= '1;
      bitsLeft  <= '0;
      rxShift   <= '0;
      sclDrvLow <= 1'b0;
      sdaDrvLow <= 1'b0;
      opDone    <= 1'b0;
    end else begin
      opDone <= 1'b0;
      unique case (dpState)
        DP_IDLE: begin
          if (ops.doStart) begin
            dpState   <= DP_S1;
            sclDrvLow <= 1'b1;
            sdaDrvLow <= 1'b0;
            cnt       <= sclLowCnt;
          end else if (ops.doStop) begin
            dpState   <= DP_P1;
            sclDrvLow <= 1'b1;
            sdaDrvLow <= 1'b1;
            cnt       <= sclLowCnt;
          end else if (ops.doWrite) begin
            dpState   <= DP_BLO;
            txShift   <= {ops.wrByte, 1'b1};
            bitsLeft  <= BITS_W'(FRAME_BITS);
            sclDrvLow <= 1'b1;
            sdaDrvLow <= ~ops.wrByte[7];
            cnt       <= sclLowCnt;
          end else if (ops.doRead) begin
            dpState   <= DP_BLO;
            txShift   <= '1;
            bitsLeft  <= BITS_W'(FRAME_BITS - 1);
            sclDrvLow <= 1'b1;
            sdaDrvLow <= 1'b0;
            cnt       <= sclLowCnt;
          end else if (ops.doAck) begin
            dpState   <= DP_BLO;
            txShift   <= {ops.ackVal, {(FRAME_BITS-1){1'b1}}};
            bitsLeft  <= BITS_W'(1);
            sclDrvLow <= 1'b1;
            sdaDrvLow <= ~ops.ackVal;
            cnt       <= sclLowCnt;
          end
        end
        DP_S1: begin
          if (cntZero) begin
            dpState   <= DP_S2;
            sclDrvLow <= 1'b0;
            cnt       <= sclHighCnt;
          end else cnt <= cnt - 1'b1;
        end
        DP_S2: begin
          if (sclIn) begin
            if (cntZero) begin
              dpState   <= DP_S3;
              sdaDrvLow <= 1'b1;
              cnt       <= sclHighCnt;
            end else cnt <= cnt - 1'b1;
          end
        end
        DP_S3: begin
          if (cntZero) begin
            dpState   <= DP_IDLE;
            sclDrvLow <= 1'b1;
            opDone    <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        DP_P1: begin
          if (cntZero) begin
            dpState   <= DP_P2;
            sclDrvLow <= 1'b0;
            cnt       <= sclHighCnt;
          end else cnt <= cnt - 1'b1;
        end
        DP_P2: begin
          if (sclIn) begin
            if (cntZero) begin
              dpState   <= DP_P3;
              sdaDrvLow <= 1'b0;
              cnt       <= sclHighCnt;
            end else cnt <= cnt - 1'b1;
          end
        end
        DP_P3: begin
          if (cntZero) begin
            dpState <= DP_IDLE;
            opDone  <= 1'b1;
          end else cnt <= cnt - 1'b1;
        end
        DP_BLO: begin
          if (cntZero) begin
            dpState   <= DP_BHI;
            sclDrvLow <= 1'b0;
            cnt       <= sclHighCnt;
          end else cnt <= cnt - 1'b1;
        end
        DP_BHI: begin
          if (sclIn) begin
            if (cntZero) begin
              rxShift   <= {rxShift[6:0], sdaIn};
              txShift   <= {txShift[FRAME_BITS-2:0], 1'b1};
              bitsLeft  <= bitsLeft - 1'b1;
              sclDrvLow <= 1'b1;
              if (bitsLeft == BITS_W'(1)) begin
                dpState <= DP_IDLE;
                opDone  <= 1'b1;
              end else begin
                dpState   <= DP_BLO;
                sdaDrvLow <= ~txShift[FRAME_BITS-2];
                cnt       <= sclLowCnt;
              end
            end else cnt <= cnt - 1'b1;
          end
        end
        default: dpState <= DP_IDLE;
      endcase
    end
  end

  // a new operation may only be requested while the bit engine is idle
  a_r7_op_only_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (ops.doStart || ops.doStop || ops.doWrite || ops.doRead || ops.doAck) |-> (dpState == DP_IDLE));

  a_r7_single_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ops.doStart, ops.doStop, ops.doWrite, ops.doRead, ops.doAck}));

  // SDA must not move while SCL is released inside a byte (R10 timing frame)
  a_r10_sda_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (dpState == DP_BHI && $past(dpState) == DP_BHI) |-> $stable(sdaDrvLow));

endmodule

// File: rtl/i2c_cmd_ctrl.sv
module i2c_cmd_ctrl
  import i2c_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdCode,
  input  logic [7:0] cmdData,
  input  logic       opDone,
  input  logic [7:0] rxShift,
  output dpOps_t     ops,
  output logic [2:0] stateCode,
  output logic       pending,
  output logic       dmaReq,
  output logic       cmdErr,
  output logic [7:0] rxByte
);

  typedef enum logic [2:0] {
    SQ_WAIT, SQ_ACK, SQ_START, SQ_ADDR, SQ_WDATA, SQ_READ, SQ_STOP
  } seq_e;

  seq_e  seq;
  code_e code;
  cmd_e  savedCmd;
  cmd_e  cmdIn;
  logic [7:0] addrByte;
  logic  legalCmd;

  assign cmdIn = cmd_e'(cmdCode);

  always_comb begin
    unique case (cmdIn)
      CMD_START: legalCmd = 1'b1;
      CMD_CONT:  legalCmd = (code == ST_RXRDY) || (code == ST_TXRDY);
      CMD_STOP:  legalCmd = (code != ST_IDLE);
      default:   legalCmd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seq      <= SQ_WAIT;
      code     <= ST_IDLE;
      savedCmd <= CMD_NONE;
      addrByte <= '0;
      ops      <= '0;
      cmdErr   <= 1'b0;
      rxByte   <= '0;
    end else begin
      ops <= '0;
      if (seq == SQ_WAIT) begin
        if (cmdValid) begin
          if (!legalCmd) begin
            cmdErr <= 1'b1;
          end else if (code == ST_RXRDY) begin
            // decide the acknowledge of the held byte first
            seq        <= SQ_ACK;
            savedCmd   <= cmdIn;
            ops.doAck  <= 1'b1;
            ops.ackVal <= (cmdIn != CMD_CONT);
            if (cmdIn == CMD_START) addrByte <= cmdData;
          end else if (cmdIn == CMD_START) begin
            seq         <= SQ_START;
            addrByte    <= cmdData;
            ops.doStart <= 1'b1;
          end else if (cmdIn == CMD_CONT) begin
            seq         <= SQ_WDATA;
            ops.doWrite <= 1'b1;
            ops.wrByte  <= cmdData;
          end else begin
            seq        <= SQ_STOP;
            ops.doStop <= 1'b1;
          end
        end
      end else begin
        if (cmdValid) cmdErr <= 1'b1;
        if (opDone) begin
          unique case (seq)
            SQ_ACK: begin
              if (savedCmd == CMD_CONT) begin
                seq        <= SQ_READ;
                ops.doRead <= 1'b1;
              end else if (savedCmd == CMD_START) begin
                seq         <= SQ_START;
                ops.doStart <= 1'b1;
              end else begin
                seq        <= SQ_STOP;
                ops.doStop <= 1'b1;
              end
            end
            SQ_START: begin
              seq         <= SQ_ADDR;
              ops.doWrite <= 1'b1;
              ops.wrByte  <= addrByte;
            end
            SQ_ADDR: begin
              if (rxShift[0]) begin
                seq  <= SQ_WAIT;
                code <= ST_ADDRNAK;
              end else if (addrByte[0]) begin
                seq        <= SQ_READ;
                ops.doRead <= 1'b1;
              end else begin
                seq  <= SQ_WAIT;
                code <= ST_TXRDY;
              end
            end
            SQ_WDATA: begin
              seq  <= SQ_WAIT;
              code <= rxShift[0] ? ST_DATANAK : ST_TXRDY;
            end
            SQ_READ: begin
              seq    <= SQ_WAIT;
              code   <= ST_RXRDY;
              rxByte <= rxShift;
            end
            SQ_STOP: begin
              seq  <= SQ_WAIT;
              code <= ST_IDLE;
            end
            default: seq <= SQ_WAIT;
          endcase
        end
      end
    end
  end

  assign stateCode = code;
  assign pending   = (seq == SQ_WAIT);
  assign dmaReq    = pending && ((code == ST_RXRDY) || (code == ST_TXRDY));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    cmdErr |=> cmdErr);

  a_r7_pending_drop: assert property (@(posedge clk) disable iff (!rstN)
    (pending && cmdValid && legalCmd) |=> !pending);

  a_r4_addr_nak_code: assert property (@(posedge clk) disable iff (!rstN)
    (seq == SQ_ADDR && opDone && rxShift[0]) |=> (pending && stateCode == 3'd3));

  a_r6_dma_with_pending: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaReq) |-> $rose(pending));

  a_r5_code_range: assert property (@(posedge clk) disable iff (!rstN)
    stateCode <= 3'd4);

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2c_cmd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] sclLowCnt,
  input  logic [DIV_W-1:0] sclHighCnt,
  input  logic             cmdValid,
  input  logic [1:0]       cmdCode,
  input  logic [7:0]       cmdData,
  output logic [2:0]       stateCode,
  output logic             pending,
  output logic             dmaReq,
  output logic             cmdErr,
  output logic [7:0]       rxByte,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclDrive,
  output logic             sdaDrive
);

  dpOps_t     ops;
  logic       opDone;
  logic [7:0] rxShift;

  i2c_cmd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdCode   (cmdCode),
    .cmdData   (cmdData),
    .opDone    (opDone),
    .rxShift   (rxShift),
    .ops       (ops),
    .stateCode (stateCode),
    .pending   (pending),
    .dmaReq    (dmaReq),
    .cmdErr    (cmdErr),
    .rxByte    (rxByte)
  );

  i2c_cmd_dp #(.DIV_W(DIV_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ops        (ops),
    .sclLowCnt  (sclLowCnt),
    .sclHighCnt (sclHighCnt),
    .sclIn      (sclIn),
    .sdaIn      (sdaIn),
    .sclDrvLow  (sclDrive),
    .sdaDrvLow  (sdaDrive),
    .opDone     (opDone),
    .rxShift    (rxShift)
  );

endmodule

// File: tb/i2c_cmd_master_test.sv
`timescale 1ns/1ps
module i2c_cmd_master_test;

  localparam logic [1:0] C_NONE = 2'd0, C_START = 2'd1, C_CONT = 2'd2, C_STOP = 2'd3;
  localparam logic [6:0] SADDR = 7'h2C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] sclLowCnt = 8'd3, sclHighCnt = 8'd2;
  logic cmdValid = 1'b0;
  logic [1:0] cmdCode = 2'd0;
  logic [7:0] cmdData = 8'd0;
  logic [2:0] stateCode;
  logic pending, dmaReq, cmdErr;
  logic [7:0] rxByte;
  logic sclDrive, sdaDrive;
  logic sSdaLow;
  logic sclBus, sdaBus;

  assign sclBus = ~sclDrive;
  assign sdaBus = ~(sdaDrive | sSdaLow);

  i2c_cmd_master uut (
    .clk(clk), .rstN(rstN), .sclLowCnt(sclLowCnt), .sclHighCnt(sclHighCnt),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdData(cmdData),
    .stateCode(stateCode), .pending(pending), .dmaReq(dmaReq), .cmdErr(cmdErr),
    .rxByte(rxByte), .sclIn(sclBus), .sdaIn(sdaBus),
    .sclDrive(sclDrive), .sdaDrive(sdaDrive)
  );

  always #4 clk = ~clk;

  int testsRun = 0, testsFailed = 0, cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural slave ----------------
  logic cfgNackAddr = 1'b0, cfgNackData = 1'b0;
  logic prevScl, prevSda, active, isAddr, rwRead, transmitting, mNack, addrAck;
  int n, txCount, stopCount;
  logic [7:0] rxSh, txB, sLastRx;

  function automatic logic [7:0] slaveByte(input int k);
    return 8'h5A ^ 8'(k * 29);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      prevScl = 1'b1; prevSda = 1'b1; active = 1'b0; isAddr = 1'b0; rwRead = 1'b0;
      transmitting = 1'b0; mNack = 1'b0; addrAck = 1'b0; n = 0; txCount = 0;
      stopCount = 0; rxSh = 8'd0; txB = 8'd0; sLastRx = 8'd0; sSdaLow <= 1'b0;
    end else begin
      if (prevScl && sclBus && prevSda && !sdaBus) begin
        active = 1'b1; n = 0; isAddr = 1'b1; transmitting = 1'b0; sSdaLow <= 1'b0;
      end else if (prevScl && sclBus && !prevSda && sdaBus) begin
        active = 1'b0; transmitting = 1'b0; stopCount++; sSdaLow <= 1'b0;
      end else if (active && !prevScl && sclBus) begin
        if (n < 8) begin
          if (!transmitting) rxSh = {rxSh[6:0], sdaBus};
        end else if (n == 8 && transmitting) mNack = sdaBus;
        n++;
      end else if (active && prevScl && !sclBus) begin
        if (n == 8) begin
          if (!transmitting) begin
            if (isAddr) begin
              addrAck = (rxSh[7:1] == SADDR) && !cfgNackAddr;
              rwRead = rxSh[0];
              sSdaLow <= addrAck;
            end else begin
              sLastRx = rxSh;
              sSdaLow <= !cfgNackData;
            end
          end else sSdaLow <= 1'b0;
        end else if (n == 9) begin
          n = 0;
          if (isAddr) begin
            isAddr = 1'b0;
            if (!addrAck) active = 1'b0;
            else if (rwRead) transmitting = 1'b1;
          end else if (transmitting && mNack) transmitting = 1'b0;
          if (transmitting) begin
            txB = slaveByte(txCount); txCount++; sSdaLow <= !txB[7];
          end else sSdaLow <= 1'b0;
        end else if (n >= 1 && n <= 7 && transmitting) sSdaLow <= !txB[7-n];
        else sSdaLow <= 1'b0;
      end
      prevScl = sclBus; prevSda = sdaBus;
    end
  end

  // SCL run-length monitor
  int runLen = 0, lastHigh = 0, lastLow = 0;
  logic runLvl = 1'b1;
  always @(negedge clk) begin
    if (sclBus == runLvl) runLen++;
    else begin
      if (runLvl) lastHigh = runLen; else lastLow = runLen;
      runLen = 1; runLvl = sclBus;
    end
  end

  // ---------------- host tasks ----------------
  int expIdx = 0;

  task automatic waitReady();
    int k = 0;
    while (!pending && k < 40000) begin @(negedge clk); k++; end
  endtask

  task automatic doCmd(input logic [1:0] c, input logic [7:0] d);
    @(negedge clk); cmdValid = 1'b1; cmdCode = c; cmdData = d;
    @(negedge clk); cmdValid = 1'b0; cmdCode = C_NONE;
    check(!pending, "R7 pending low after command", pending, 0);
    waitReady();
  endtask

  task automatic doReset();
    rstN = 1'b0; cmdValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1; expIdx = 0;
    @(negedge clk);
  endtask

  function automatic logic [2:0] expAddrCode(input logic [7:0] a, input logic nak);
    if (a[7:1] != SADDR || nak) return 3'd3;
    return a[0] ? 3'd1 : 3'd2;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    doReset();
    check(stateCode == 0, "R1 reset code", stateCode, 0);
    check(pending == 1, "R1 reset pending", pending, 1);
    check(dmaReq == 0 && cmdErr == 0, "R1 reset dma/err", {dmaReq, cmdErr}, 0);
    check(!sclDrive && !sdaDrive, "R1 reset bus", {sclDrive, sdaDrive}, 0);

    // R9: illegal in idle
    @(negedge clk); cmdValid = 1; cmdCode = C_CONT; @(negedge clk); cmdValid = 0;
    repeat (4) @(negedge clk);
    check(cmdErr == 1, "R9 continue in idle sets error", cmdErr, 1);
    check(stateCode == 0 && pending == 1, "R9 continue in idle ignored", stateCode, 0);
    check(sclBus && sdaBus, "R9 bus untouched", {sclBus, sdaBus}, 3);

    // directed write / nack / repeated start read
    doReset();
    doCmd(C_START, {SADDR, 1'b0});
    check(stateCode == 2, "R2 write address acked", stateCode, 2);
    check(dmaReq == 1, "R6 dma in state 2", dmaReq, 1);
    doCmd(C_CONT, 8'hC3);
    check(stateCode == 2, "R5 data acked", stateCode, 2);
    check(sLastRx == 8'hC3, "R5 byte at slave", sLastRx, 8'hC3);
    check(lastHigh == 3 && lastLow == 4, "R10 phases l=3 h=2", {lastLow, lastHigh}, 32'h0403);
    sclLowCnt = 8'd5; sclHighCnt = 8'd1;
    doCmd(C_CONT, 8'h3C);
    check(lastHigh == 2 && lastLow == 6, "R10 phases l=5 h=1", {lastLow, lastHigh}, 32'h0602);
    sclLowCnt = 8'd3; sclHighCnt = 8'd2;
    cfgNackData = 1;
    doCmd(C_CONT, 8'h77);
    cfgNackData = 0;
    check(stateCode == 4, "R5 data nacked", stateCode, 4);
    check(dmaReq == 0, "R6 no dma in state 4", dmaReq, 0);
    @(negedge clk); cmdValid = 1; cmdCode = C_CONT; cmdData = 8'h11; @(negedge clk); cmdValid = 0;
    repeat (4) @(negedge clk);
    check(cmdErr == 1 && stateCode == 4 && pending, "R9 continue in state 4 ignored", stateCode, 4);
    doCmd(C_START, {SADDR, 1'b1});
    check(stateCode == 1, "R11 repeated start to read", stateCode, 1);
    check(rxByte == slaveByte(0), "R3 first read byte", rxByte, slaveByte(0));
    check(dmaReq == 1, "R6 dma in state 1", dmaReq, 1);
    doCmd(C_CONT, 8'h00);
    check(mNack == 0, "R8 continue acks byte", mNack, 0);
    check(rxByte == slaveByte(1), "R8 next read byte", rxByte, slaveByte(1));
    doCmd(C_STOP, 8'h00);
    check(mNack == 1, "R8 stop nacks last byte", mNack, 1);
    check(stateCode == 0 && sclBus && sdaBus, "R11 stop releases bus", stateCode, 0);
    check(dmaReq == 0, "R6 no dma in state 0", dmaReq, 0);

    // R9 command while busy
    doReset();
    @(negedge clk); cmdValid = 1; cmdCode = C_START; cmdData = {SADDR, 1'b0};
    @(negedge clk); cmdCode = C_STOP;
    @(negedge clk); cmdValid = 0;
    waitReady();
    check(cmdErr == 1, "R9 busy command sets error", cmdErr, 1);
    check(stateCode == 2, "R9 busy stop ignored", stateCode, 2);
    doCmd(C_STOP, 8'h00);

    // R4 address nack, then repeated start from 3
    doReset();
    cfgNackAddr = 1;
    doCmd(C_START, {SADDR, 1'b0});
    cfgNackAddr = 0;
    check(stateCode == 3, "R4 address nacked", stateCode, 3);
    check(dmaReq == 0, "R6 no dma in state 3", dmaReq, 0);
    check(cmdErr == 0, "R9 no error on legal commands", cmdErr, 0);
    doCmd(C_START, {SADDR, 1'b0});
    check(stateCode == 2, "R11 repeated start from state 3", stateCode, 2);
    doCmd(C_STOP, 8'h00);
    check(stateCode == 0 && stopCount == 1, "R11 stop seen by slave", stopCount, 1);

    // constrained random transactions
    doReset();
    for (int t = 0; t < 40; t++) begin
      logic [7:0] addr;
      logic nak;
      logic [2:0] exp;
      sclLowCnt = 8'(2 + $urandom_range(0, 3));
      sclHighCnt = 8'(1 + $urandom_range(0, 3));
      addr = ($urandom_range(0, 4) == 0) ? {7'h13, 1'($urandom)} : {SADDR, 1'($urandom)};
      nak = ($urandom_range(0, 5) == 0);
      cfgNackAddr = nak;
      doCmd(C_START, addr);
      cfgNackAddr = 0;
      exp = expAddrCode(addr, nak);
      check(stateCode == exp, "R2 random address outcome", stateCode, exp);
      if (exp == 1) begin
        check(rxByte == slaveByte(expIdx), "R3 random read", rxByte, slaveByte(expIdx));
        expIdx++;
      end
      for (int b = 0; b < 4 && (exp == 1 || exp == 2); b++) begin
        if (exp == 2) begin
          logic [7:0] d;
          logic dn;
          d = 8'($urandom);
          dn = ($urandom_range(0, 4) == 0);
          cfgNackData = dn;
          doCmd(C_CONT, d);
          cfgNackData = 0;
          exp = dn ? 3'd4 : 3'd2;
          check(stateCode == exp && sLastRx == d, "R5 random write", stateCode, exp);
        end else begin
          doCmd(C_CONT, 8'h00);
          check(mNack == 0 && rxByte == slaveByte(expIdx), "R8 random read continue",
                rxByte, slaveByte(expIdx));
          expIdx++;
        end
        check(dmaReq == (exp == 1 || exp == 2), "R6 random dma", dmaReq, (exp == 1 || exp == 2));
      end
      doCmd(C_STOP, 8'h00);
      check(stateCode == 0 && sclBus && sdaBus, "R11 random stop", stateCode, 0);
    end
    check(cmdErr == 0, "R9 random legal run no error", cmdErr, 0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule